// File: doc/BRIEF.md
# Copy Engine Port Interrupt Controller

This block gathers completion and fault events from the ports of a multi-port copy engine. It keeps them in a status word and turns them into per-port wake-up and interrupt lines. Each port owns two status flags. The first is a yield flag, which is meant to wake a waiting hardware thread. The second is an interrupt flag, whose output can be held back by a per-port interval counter. Software clears these flags with write-one acknowledges. Two global flags record a command fault and a length fault.

Software programs the block through a single-cycle register bus. A control word holds a master enable, a per-port enable mask and a soft-reset bit. Writing 1 to the soft-reset bit clears the event state for a fixed number of cycles. The bit then falls back to 0 by itself, and software polls it to learn that the clear has finished. Reads are combinational. Word addresses: control 0x00, status 0x01, output enable 0x02, output mask 0x03, capture enable 0x04, and the interval register of port p at 0x10+p. Any other address reads 0.

Top module: `cpe_irq_ctrl`

## Requirements
- R1: After reset the following read 0: control, status, output enable, output mask and every interval register. Capture enable reads 0x3FFFF, and all outputs are low. Each register reads back the value written to its address, limited to its width (16 bits for intervals). Unmapped addresses read 0.
- R2: A `port_done` pulse on port p is captured on the next clock edge only if three conditions all hold: control bit 0 (master enable), control bit 8+p (port enable) and the matching capture-enable bit. When captured, it sets status bit 2p (yield) and status bit 2p+1 (interrupt). Each of the two bits has its own capture-enable bit, at the same position. A pulse that fails these conditions leaves status unchanged.
- R3: Writing the status address clears every status bit whose data bit is 1 and leaves the others unchanged. Writing both bits of a port acknowledges that port.
- R4: If an event sets a status bit in the same cycle that a write-one tries to clear it, the bit ends up set. Other bits cleared by the same write still clear.
- R5: `cmd_err` sets status bit 16 and `len_err` sets status bit 17. Each is gated only by its capture-enable bit, and each is cleared by write-one. `err_irq` is high while either bit is set, enabled in the output enable register and not masked in the output mask register.
- R6: `port_yield[p]` equals status bit 2p AND output-enable bit 2p AND NOT output-mask bit 2p.
- R7: `port_irq[p]` needs all of the following: status bit 2p+1 set, output-enable bits 2p+1 and 2p both set, output-mask bit 2p+1 clear, and the interval elapsed. With the yield enable bit 2p clear, the output stays low.
- R8: Call the value in the port's interval register N. `port_irq[p]` can rise no earlier than N clock edges after the edge that set interrupt status bit 2p+1, and it can rise directly when N is 0. Clearing the bit restarts the count.
- R9: Writing 1 to control bit 4 makes that bit read 1 for exactly 4 cycles, then 0. It clears control, status, output enable, output mask and the interval counters, and returns capture enable to all-ones. While the bit reads 1, events and register writes are ignored and all outputs are low. Interval registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| port_done | input | 8 | Per-port completion pulses |
| cmd_err | input | 1 | Command fault pulse |
| len_err | input | 1 | Length fault pulse |
| port_yield | output | 8 | Per-port wake-up lines |
| port_irq | output | 8 | Per-port interrupt lines |
| err_irq | output | 1 | Fault interrupt line |

## Verification
A write-one acknowledge to the status word can land in the same cycle as a new completion pulse. This is the case where a port's flag could be lost. The bench provokes it by driving a status write and a `port_done` pulse in one cycle. The write clears the bits of one port that are already set, and it also carries 1s for the port that the pulse is setting. The following status read must show the new event kept and the old one removed. A second collision is a register write and an event arriving during the soft-reset window. Both must leave no trace.

// File: rtl/cpe_irq_pkg.sv
package cpe_irq_pkg;

    // Word addresses of the register file
    localparam int unsigned REG_CTRL     = 0;
    localparam int unsigned REG_STAT     = 1;
    localparam int unsigned REG_OUT_EN   = 2;
    localparam int unsigned REG_OUT_MASK = 3;
    localparam int unsigned REG_CAP_EN   = 4;
    localparam int unsigned REG_IVL_BASE = 16;

    // Control word fields
    localparam int unsigned CTRL_GEN_BIT   = 0;
    localparam int unsigned CTRL_SRST_BIT  = 4;
    localparam int unsigned CTRL_PMASK_LSB = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_OUT_EN,
        SEL_OUT_MASK,
        SEL_CAP_EN,
        SEL_IVL
    } reg_sel_e;

endpackage

// File: rtl/cpe_reg_decode.sv
module cpe_reg_decode
    import cpe_irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned NUM_PORTS = 8,
    localparam int unsigned PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [PIDX_W-1:0] ivl_idx
);

    int unsigned a_int;

    always_comb begin
        a_int   = {{(32-ADDR_W){1'b0}}, addr};
        ivl_idx = addr[PIDX_W-1:0];
        sel     = SEL_NONE;
        if (a_int == REG_CTRL)          sel = SEL_CTRL;
        else if (a_int == REG_STAT)     sel = SEL_STAT;
        else if (a_int == REG_OUT_EN)   sel = SEL_OUT_EN;
        else if (a_int == REG_OUT_MASK) sel = SEL_OUT_MASK;
        else if (a_int == REG_CAP_EN)   sel = SEL_CAP_EN;
        else if (a_int >= REG_IVL_BASE && a_int < REG_IVL_BASE + NUM_PORTS)
            sel = SEL_IVL;
    end

endmodule

// File: rtl/cpe_srst_seq.sv
module cpe_srst_seq #(
    parameter int unsigned CYCLES = 4,
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.cnt == '0) seq_d.busy = 1'b0;
            else                 seq_d.cnt  = seq_q.cnt - 1'b1;
        end else if (start) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;

endmodule

// File: rtl/cpe_ivl_timer.sv
module cpe_ivl_timer #(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             armed,
    input  logic [IVL_W-1:0] ivl,
    output logic             expired
);

    logic [IVL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || !armed)  cnt_d = '0;
        else if (cnt_q < ivl) cnt_d = cnt_q + 1'b1;
        else                cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = armed && (cnt_q >= ivl);

endmodule

// File: rtl/cpe_irq_ctrl.sv
module cpe_irq_ctrl
    import cpe_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IVL_W       = 16,
    parameter int unsigned SRST_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_PORTS-1:0] port_done,
    input  logic                 cmd_err,
    input  logic                 len_err,
    output logic [NUM_PORTS-1:0] port_yield,
    output logic [NUM_PORTS-1:0] port_irq,
    output logic                 err_irq
);

    localparam int unsigned STAT_W      = 2 * NUM_PORTS + 2;
    localparam int unsigned CMD_ERR_BIT = 2 * NUM_PORTS;
    localparam int unsigned LEN_ERR_BIT = 2 * NUM_PORTS + 1;
    localparam int unsigned PIDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic                            gen;
        logic [NUM_PORTS-1:0]            pmask;
        logic [STAT_W-1:0]               status;
        logic [STAT_W-1:0]               out_en;
        logic [STAT_W-1:0]               out_mask;
        logic [STAT_W-1:0]               cap_en;
        logic [NUM_PORTS-1:0][IVL_W-1:0] ivl;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e          sel;
    logic [PIDX_W-1:0] ivl_idx;
    logic              srst_busy;
    logic              srst_start;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] w1c_vec;
    logic [STAT_W-1:0] stat_vec;
    logic [STAT_W-1:0] en_vec;
    logic [NUM_PORTS-1:0] tmr_exp;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata;

    cpe_reg_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS)
    ) u_dec (
        .addr    (reg_addr),
        .sel     (sel),
        .ivl_idx (ivl_idx)
    );

    assign srst_start = reg_wr && (sel == SEL_CTRL) && reg_wdata[CTRL_SRST_BIT] && !srst_busy;

    cpe_srst_seq #(
        .CYCLES (SRST_CYCLES)
    ) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (srst_busy)
    );

    // Event capture and acknowledge vectors
    always_comb begin
        set_vec = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            set_vec[2*p]   = port_done[p] && st_q.gen && st_q.pmask[p] && st_q.cap_en[2*p];
            set_vec[2*p+1] = port_done[p] && st_q.gen && st_q.pmask[p] && st_q.cap_en[2*p+1];
        end
        set_vec[CMD_ERR_BIT] = cmd_err && st_q.cap_en[CMD_ERR_BIT];
        set_vec[LEN_ERR_BIT] = len_err && st_q.cap_en[LEN_ERR_BIT];
        if (srst_busy || srst_start) set_vec = '0;
        w1c_vec = (reg_wr && sel == SEL_STAT && !srst_busy) ? reg_wdata[STAT_W-1:0] : '0;
    end

    // Next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.status = (st_q.status & ~w1c_vec) | set_vec;
        if (reg_wr) begin
            case (sel)
                SEL_CTRL: begin
                    st_d.gen   = reg_wdata[CTRL_GEN_BIT];
                    st_d.pmask = reg_wdata[CTRL_PMASK_LSB +: NUM_PORTS];
                end
                SEL_OUT_EN:   st_d.out_en   = reg_wdata[STAT_W-1:0];
                SEL_OUT_MASK: st_d.out_mask = reg_wdata[STAT_W-1:0];
                SEL_CAP_EN:   st_d.cap_en   = reg_wdata[STAT_W-1:0];
                SEL_IVL:      st_d.ivl[ivl_idx] = reg_wdata[IVL_W-1:0];
                default: ;
            endcase
        end
        if (srst_start || srst_busy) begin
            st_d.gen      = 1'b0;
            st_d.pmask    = '0;
            st_d.status   = '0;
            st_d.out_en   = '0;
            st_d.out_mask = '0;
            st_d.cap_en   = '1;
            st_d.ivl      = st_q.ivl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gen      <= 1'b0;
            st_q.pmask    <= '0;
            st_q.status   <= '0;
            st_q.out_en   <= '0;
            st_q.out_mask <= '0;
            st_q.cap_en   <= '1;
            st_q.ivl      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_vec = st_q.status;
    assign en_vec   = st_q.out_en;

    // Per-port interval timers and output gating
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            cpe_ivl_timer #(
                .IVL_W (IVL_W)
            ) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (srst_busy),
                .armed   (st_q.status[2*p+1]),
                .ivl     (st_q.ivl[p]),
                .expired (tmr_exp[p])
            );

            assign port_yield[p] = st_q.status[2*p] && st_q.out_en[2*p] && !st_q.out_mask[2*p];
            assign port_irq[p]   = st_q.status[2*p+1] && st_q.out_en[2*p+1] && st_q.out_en[2*p]
                                   && !st_q.out_mask[2*p+1] && tmr_exp[p];
        end
    endgenerate

    assign err_irq = |(st_q.status[LEN_ERR_BIT:CMD_ERR_BIT] & st_q.out_en[LEN_ERR_BIT:CMD_ERR_BIT]
                       & ~st_q.out_mask[LEN_ERR_BIT:CMD_ERR_BIT]);

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                reg_rdata[CTRL_GEN_BIT]                   = st_q.gen;
                reg_rdata[CTRL_SRST_BIT]                  = srst_busy;
                reg_rdata[CTRL_PMASK_LSB +: NUM_PORTS]    = st_q.pmask;
            end
            SEL_STAT:     reg_rdata[STAT_W-1:0] = st_q.status;
            SEL_OUT_EN:   reg_rdata[STAT_W-1:0] = st_q.out_en;
            SEL_OUT_MASK: reg_rdata[STAT_W-1:0] = st_q.out_mask;
            SEL_CAP_EN:   reg_rdata[STAT_W-1:0] = st_q.cap_en;
            SEL_IVL:      reg_rdata[IVL_W-1:0]  = st_q.ivl[ivl_idx];
            default: ;
        endcase
    end

endmodule

// File: rtl/cpe_irq_chk.sv
module cpe_irq_chk #(
    parameter int unsigned NUM_PORTS   = 8,
    parameter int unsigned SRST_CYCLES = 4,
    localparam int unsigned STAT_W     = 2 * NUM_PORTS + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic [STAT_W-1:0]    status,
    input logic [STAT_W-1:0]    out_en,
    input logic [STAT_W-1:0]    set_vec,
    input logic [STAT_W-1:0]    w1c_vec,
    input logic [NUM_PORTS-1:0] port_irq,
    input logic [NUM_PORTS-1:0] port_yield
);

    logic [NUM_PORTS-1:0] yld_stat, irq_stat, yld_en;
    int unsigned busy_run;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            yld_stat[p] = status[2*p];
            irq_stat[p] = status[2*p+1];
            yld_en[p]   = out_en[2*p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R2
    capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|w1c_vec) |=> ((status & $past(w1c_vec) & ~$past(set_vec)) == '0));

    // R6
    yield_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_yield & ~yld_stat) == '0);

    // R7
    irq_needs_yield_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_irq & ~(yld_en & irq_stat)) == '0);

    // R9
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (port_irq == '0 && port_yield == '0 && status == '0));

    // R9
    srst_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < SRST_CYCLES));

endmodule

bind cpe_irq_ctrl cpe_irq_chk #(
    .NUM_PORTS   (NUM_PORTS),
    .SRST_CYCLES (SRST_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (srst_busy),
    .status     (stat_vec),
    .out_en     (en_vec),
    .set_vec    (set_vec),
    .w1c_vec    (w1c_vec),
    .port_irq   (port_irq),
    .port_yield (port_yield)
);

// File: tb/sim_cpe_irq_ctrl.sv
module sim_cpe_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 100000;

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_EV = 2'd2;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h01;
    localparam logic [4:0] A_EN   = 5'h02;
    localparam logic [4:0] A_MASK = 5'h03;
    localparam logic [4:0] A_CEN  = 5'h04;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [7:0]  done;
        logic [1:0]  err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [0:NV-1] = '{
        '{K_RD, A_CTRL, 32'h0,       8'h00, 2'b00, 4'd1},  // R1
        '{K_RD, A_STAT, 32'h0,       8'h00, 2'b00, 4'd1},  // R1
        '{K_RD, A_CEN,  32'h3FFFF,   8'h00, 2'b00, 4'd1},  // R1
        '{K_RD, A_EN,   32'h0,       8'h00, 2'b00, 4'd1},  // R1
        '{K_RD, 5'h17,  32'h0,       8'h00, 2'b00, 4'd1},  // R1
        '{K_EV, 5'h00,  32'h0,       8'h01, 2'b00, 4'd2},  // R2 master enable off
        '{K_RD, A_STAT, 32'h0,       8'h00, 2'b00, 4'd2},  // R2
        '{K_WR, A_CTRL, 32'h501,     8'h00, 2'b00, 4'd1},
        '{K_RD, A_CTRL, 32'h501,     8'h00, 2'b00, 4'd1},  // R1 readback
        '{K_EV, 5'h00,  32'h0,       8'h06, 2'b00, 4'd2},  // R2 port 1 disabled
        '{K_RD, A_STAT, 32'h30,      8'h00, 2'b00, 4'd2},  // R2
        '{K_WR, A_CEN,  32'h3FFFE,   8'h00, 2'b00, 4'd2},
        '{K_EV, 5'h00,  32'h0,       8'h01, 2'b00, 4'd2},
        '{K_RD, A_STAT, 32'h32,      8'h00, 2'b00, 4'd2},  // R2 per-bit capture
        '{K_WR, A_STAT, 32'h10,      8'h00, 2'b00, 4'd3},
        '{K_RD, A_STAT, 32'h22,      8'h00, 2'b00, 4'd3},  // R3
        '{K_WR, A_STAT, 32'h22,      8'h00, 2'b00, 4'd3},
        '{K_RD, A_STAT, 32'h0,       8'h00, 2'b00, 4'd3},  // R3
        '{K_EV, 5'h00,  32'h0,       8'h00, 2'b11, 4'd5},
        '{K_RD, A_STAT, 32'h30000,   8'h00, 2'b00, 4'd5},  // R5
        '{K_WR, A_STAT, 32'h10000,   8'h00, 2'b00, 4'd5},
        '{K_RD, A_STAT, 32'h20000,   8'h00, 2'b00, 4'd5},  // R5
        '{K_WR, A_CEN,  32'h3FFFF,   8'h00, 2'b00, 4'd1},
        '{K_WR, 5'h12,  32'hFFFFABCD, 8'h00, 2'b00, 4'd1},
        '{K_RD, 5'h12,  32'hABCD,    8'h00, 2'b00, 4'd1},  // R1 width limit
        '{K_RD, 5'h0A,  32'h0,       8'h00, 2'b00, 4'd1},  // R1 unmapped
        '{K_WR, A_STAT, 32'h20000,   8'h00, 2'b00, 4'd5},
        '{K_RD, A_STAT, 32'h0,       8'h00, 2'b00, 4'd5}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  port_done = '0;
    logic        cmd_err = 1'b0;
    logic        len_err = 1'b0;
    logic [7:0]  port_yield;
    logic [7:0]  port_irq;
    logic        err_irq;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpe_irq_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .port_done  (port_done),
        .cmd_err    (cmd_err),
        .len_err    (len_err),
        .port_yield (port_yield),
        .port_irq   (port_irq),
        .err_irq    (err_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic pulse(input logic [7:0] d, input logic [1:0] e);
        @(negedge clk);
        port_done = d; {len_err, cmd_err} = e;
        @(negedge clk);
        port_done = '0; {len_err, cmd_err} = 2'b00;
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 outputs after reset
        chk({8'h0, port_yield, port_irq, 7'h0, err_irq}, 32'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                K_WR: wr_reg(VECS[i].addr, VECS[i].data);
                K_EV: pulse(VECS[i].done, VECS[i].err);
                default: rd_chk(VECS[i].addr, VECS[i].data, $sformatf("R%0d", VECS[i].req));
            endcase
        end

        // R8: interval of 3 on port 2
        wr_reg(5'h12, 32'd3);
        wr_reg(A_EN, 32'h30);
        pulse(8'h04, 2'b00);
        chk({24'h0, port_yield}, 32'h04, "R6");
        chk({24'h0, port_irq}, 32'h00, "R8");
        @(negedge clk); chk({24'h0, port_irq}, 32'h00, "R8");
        @(negedge clk); chk({24'h0, port_irq}, 32'h00, "R8");
        @(negedge clk); chk({24'h0, port_irq}, 32'h04, "R8");
        wr_reg(A_STAT, 32'h30);
        chk({16'h0, port_yield, port_irq}, 32'h0, "R3");
        pulse(8'h04, 2'b00);
        chk({24'h0, port_irq}, 32'h00, "R8");
        wr_reg(A_STAT, 32'h30);

        // R7: yield enable dependency and zero interval on port 0
        wr_reg(A_EN, 32'h02);
        pulse(8'h01, 2'b00);
        chk({24'h0, port_irq}, 32'h00, "R7");
        wr_reg(A_EN, 32'h03);
        chk({24'h0, port_irq}, 32'h01, "R7");
        wr_reg(A_MASK, 32'h02);
        chk({16'h0, port_yield, port_irq}, 32'h0100, "R7");
        wr_reg(A_MASK, 32'h01);
        chk({16'h0, port_yield, port_irq}, 32'h0001, "R6");
        wr_reg(A_MASK, 32'h0);

        // R5: fault output
        pulse(8'h00, 2'b01);
        wr_reg(A_EN, 32'h10003);
        chk({31'h0, err_irq}, 32'h1, "R5");
        wr_reg(A_MASK, 32'h10000);
        chk({31'h0, err_irq}, 32'h0, "R5");
        wr_reg(A_MASK, 32'h0);

        // R4: acknowledge and new event in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h33; port_done = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; port_done = '0;
        rd_chk(A_STAT, 32'h10030, "R4");

        // R9: soft reset window
        wr_reg(A_CTRL, 32'h10);
        rd_chk(A_CTRL, 32'h10, "R9");
        chk({16'h0, port_yield, port_irq}, 32'h0, "R9");
        reg_wr = 1'b1; reg_addr = A_EN; reg_wdata = 32'hFFFF; port_done = 8'hFF;
        @(negedge clk);
        reg_wr = 1'b0; port_done = '0;
        rd_chk(A_EN, 32'h0, "R9");
        rd_chk(A_STAT, 32'h0, "R9");
        @(negedge clk); rd_chk(A_CTRL, 32'h10, "R9");
        @(negedge clk); rd_chk(A_CTRL, 32'h10, "R9");
        @(negedge clk); rd_chk(A_CTRL, 32'h00, "R9");
        rd_chk(A_CEN, 32'h3FFFF, "R9");
        rd_chk(5'h12, 32'd3, "R9");
        rd_chk(A_MASK, 32'h0, "R9");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule